// File: doc/BRIEF.md
# Programmable Countdown Timer with Reload

The block counts down from a software-chosen 8-bit value n at one of four tick rates taken from a 4096 Hz reference clock. It reaches the end of a period when the count would pass from 1 to 0. At that moment it emits a one-cycle period-end pulse and loads n again, so the timer runs on without help. The pulse is meant to set a timer flag held elsewhere. The live count is always visible on an output, so a read returns the value at that moment and not n. Software should read twice and compare the two results.

The enable is driven from a register interface clocked by an unrelated clock. It passes through a two-flop synchroniser into the timer domain. The count loads n on the synchronised rising edge of the enable. On that same edge the prescaler stages above the middle rate restart. Because of this, only the first period after enable has a bounded uncertainty. Every later period is exact. A value of n = 0 keeps the timer idle.

Top module: `cd_timer`

## Requirements
- R1: sel_i picks the tick source. 0 ticks on every clock (the 4096 Hz reference). 1 ticks once every MID_DIV clocks (64 Hz). 2 ticks once every SLOW_DIV clocks (1 Hz). 3 ticks once every MIN_DIV*SLOW_DIV clocks (1/60 Hz).
- R2: A rising edge on en_i is synchronised through two flops. count_o shows the value of reload_i on the third rising clock edge after en_i rises, and not earlier.
- R3: While enabled, count_o is the live count. It drops by one on each selected tick while it is above 1.
- R4: On a tick with count 1, period_end_o is high for the following cycle and count_o reloads reload_i. Every period after the first lasts exactly n times the tick interval.
- R5: reload_i is sampled only at a load or a reload. A change in the middle of a period does not alter the running count, and it sets the length of the next period.
- R6: The first period, measured from the load edge to the period-end edge, obeys these bounds. With source 0 it is exactly n clocks. With source 1 it is from (n-1)*MID_DIV+1 to n*MID_DIV clocks. With sources 2 and 3 it is from n*P-MID_DIV+1 to n*P clocks, where P is the tick interval.
- R7: With n = 0 the count stays at 0 and period_end_o never rises.
- R8: When en_i falls, counting stops two edges later and count_o holds its value with no period events. The next enable loads n again.
- R9: While rst_ni is low, count_o is 0 and period_end_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 4096 Hz timer-domain reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Timer enable from the asynchronous interface domain |
| sel_i | input | 2 | Tick source select (0 ref, 1 mid, 2 slow, 3 minute) |
| reload_i | input | CNT_W | Reload value n |
| count_o | output | CNT_W | Live countdown value |
| period_end_o | output | 1 | One-cycle pulse at the end of each period |

## Verification
The bench shrinks the divider ratios so that it can measure, in clocks, the first and the steady periods for every source and for several values of n, including n = 1. A prescaler that failed to restart on enable would break the slow-source first-period bounds. An off-by-one reload would make the steady periods n±1 ticks. The bench checks the exact synchroniser latency, so a missing or extra flop shows up as the load appearing on the wrong edge. It also covers a reload value changed in mid-period, a disable that must freeze the count, and n = 0. A design that reloaded eagerly, kept counting after disable, or fired from a zero count would each fail one of these.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  typedef enum logic [1:0] {
    SRC_REF  = 2'd0,
    SRC_MID  = 2'd1,
    SRC_SLOW = 2'd2,
    SRC_MIN  = 2'd3
  } cdt_src_e;
  localparam int NUM_SRC = 4;
endpackage

// File: rtl/cdt_sync.sv
module cdt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], d_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level_o = sync_q[STAGES-1];
  assign rise_o  = sync_q[STAGES-1] & ~prev_q;

  AST_RISE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R2
endmodule

// File: rtl/cdt_prescale.sv
module cdt_prescale
  import cdt_pkg::*;
#(
  parameter int MID_DIV  = 64,
  parameter int SLOW_DIV = 4096,
  parameter int MIN_DIV  = 60
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               restart_i,
  output logic [NUM_SRC-1:0] tick_o
);
  localparam int SLOW_W = $clog2(SLOW_DIV);
  localparam int MIN_W  = $clog2(MIN_DIV);
  localparam logic [SLOW_W-1:0] LOW_MASK = SLOW_W'(MID_DIV - 1);
  localparam logic [MIN_W-1:0]  MIN_LAST = MIN_W'(MIN_DIV - 1);

  logic [SLOW_W-1:0] div_q;
  logic [MIN_W-1:0]  min_q;
  logic              tick_mid, tick_slow, tick_min;

  assign tick_mid  = (div_q & LOW_MASK) == LOW_MASK;
  assign tick_slow = &div_q;
  assign tick_min  = tick_slow && (min_q == MIN_LAST);

  // Restart clears the stages above the mid rate; the mid phase runs free.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
    end else if (restart_i) begin
      div_q <= (div_q + SLOW_W'(1)) & LOW_MASK;
    end else begin
      div_q <= div_q + SLOW_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      min_q <= '0;
    end else if (restart_i) begin
      min_q <= '0;
    end else if (tick_slow) begin
      min_q <= (min_q == MIN_LAST) ? '0 : min_q + MIN_W'(1);
    end
  end

  assign tick_o[SRC_REF]  = 1'b1;
  assign tick_o[SRC_MID]  = tick_mid;
  assign tick_o[SRC_SLOW] = tick_slow;
  assign tick_o[SRC_MIN]  = tick_min;

  AST_RESTART_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !tick_o[SRC_SLOW] && !tick_o[SRC_MIN]); // R6
  AST_MIN_ON_SLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o[SRC_MIN] |-> tick_o[SRC_SLOW]); // R1
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             period_end_o
);
  logic [CNT_W-1:0] count_q;
  logic             end_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      end_q   <= 1'b0;
    end else begin
      end_q <= 1'b0;
      if (load_i) begin
        count_q <= reload_i;
      end else if (run_i && tick_i && count_q != '0) begin
        if (count_q == CNT_W'(1)) begin
          count_q <= reload_i;
          end_q   <= 1'b1;
        end else begin
          count_q <= count_q - CNT_W'(1);
        end
      end
    end
  end

  assign count_o      = count_q;
  assign period_end_o = end_q;

  AST_LOAD_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> count_q == $past(reload_i)); // R2
  AST_DEC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && run_i && tick_i && count_q > CNT_W'(1)) |=> count_q == $past(count_q) - CNT_W'(1)); // R3
  AST_RELOAD_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_q |-> count_q == $past(reload_i)); // R4
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == '0 && !load_i) |=> count_q == '0 && !end_q); // R7
  AST_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !load_i) |=> $stable(count_q) && !end_q); // R8
endmodule

// File: rtl/cd_timer.sv
module cd_timer
  import cdt_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int MID_DIV     = 64,
  parameter int SLOW_DIV    = 4096,
  parameter int MIN_DIV     = 60,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [1:0]       sel_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             period_end_o
);
  logic               en_lvl, en_rise;
  logic [NUM_SRC-1:0] ticks;
  logic               tick_sel;

  cdt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .d_i     (en_i),
    .level_o (en_lvl),
    .rise_o  (en_rise)
  );

  cdt_prescale #(
    .MID_DIV  (MID_DIV),
    .SLOW_DIV (SLOW_DIV),
    .MIN_DIV  (MIN_DIV)
  ) u_prescale (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (en_rise),
    .tick_o    (ticks)
  );

  assign tick_sel = ticks[sel_i];

  cdt_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (en_rise),
    .run_i        (en_lvl),
    .tick_i       (tick_sel),
    .reload_i     (reload_i),
    .count_o      (count_o),
    .period_end_o (period_end_o)
  );

  AST_RESET_STATE: assert property (@(posedge clk_i)
    !rst_ni |-> count_o == '0 && !period_end_o); // R9
endmodule

// File: tb/cd_timer_test.sv
module cd_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int MID  = 4;
  localparam int SLOW = 16;
  localparam int MINDIV = 3;
  localparam int LIMIT = 5000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [1:0] sel = 2'd0;
  logic [7:0] rel = 8'd0;
  logic [7:0] count;
  logic       pe;
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cd_timer #(.MID_DIV(MID), .SLOW_DIV(SLOW), .MIN_DIV(MINDIV)) uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .sel_i(sel), .reload_i(rel),
    .count_o(count), .period_end_o(pe)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic int per(int s);
    case (s)
      0: return 1;
      1: return MID;
      2: return SLOW;
      default: return MINDIV * SLOW;
    endcase
  endfunction

  task automatic stop();
    en = 1'b0;
    repeat (4) step();
  endtask

  task automatic wait_pe(output int k);
    k = 0;
    do begin
      step();
      k++;
    end while (!pe && k < LIMIT);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) step();
    check(count == 0, "R9 count", count, 0);
    check(pe == 0, "R9 period_end", pe, 0);
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_sync_latency();
    int k;
    sel = 2'd0; rel = 8'd5;
    step();
    en = 1'b1;
    step(); step();
    check(count == 0, "R2 no early load", count, 0);
    step();
    check(count == 5, "R2 load on third edge", count, 5);
    step();
    check(count == 4, "R3 decrement", count, 4);
    step();
    check(count == 3, "R3 decrement", count, 3);
    k = 2;
    while (!pe && k < LIMIT) begin
      step();
      k++;
    end
    check(k == 5, "R4 first fast period", k, 5);
    step();
    check(pe == 0, "R4 one-cycle pulse", pe, 0);
    check(count == 4, "R4 reload then count", count, 4);
  endtask

  task automatic run_case(int s, int n);
    int k, lo, hi, p;
    p = per(s);
    stop();
    sel = 2'(s); rel = 8'(n);
    step();
    en = 1'b1;
    repeat (3) step();
    wait_pe(k);
    if (s == 0) begin lo = n; hi = n; end
    else if (s == 1) begin lo = (n - 1) * p + 1; hi = n * p; end
    else begin lo = n * p - MID + 1; hi = n * p; end
    check(k >= lo && k <= hi, $sformatf("R6 first period sel=%0d n=%0d (lo %0d)", s, n, lo), k, hi);
    for (int i = 0; i < 2; i++) begin
      wait_pe(k);
      check(k == n * p, $sformatf("R1 R4 steady period sel=%0d n=%0d", s, n), k, n * p);
    end
  endtask

  task automatic t_reload_change();
    int k;
    stop();
    sel = 2'd0; rel = 8'd6;
    step();
    en = 1'b1;
    repeat (3) step();
    step();
    rel = 8'd9;
    k = 1;
    while (!pe && k < LIMIT) begin
      step();
      k++;
    end
    check(k == 6, "R5 running period unaffected", k, 6);
    check(count == 9, "R5 new value reloaded", count, 9);
    wait_pe(k);
    check(k == 9, "R5 next period uses new value", k, 9);
  endtask

  task automatic t_disable();
    logic [7:0] held;
    bit seen;
    stop();
    sel = 2'd0; rel = 8'd20;
    step();
    en = 1'b1;
    repeat (3) step();
    repeat (4) step();
    en = 1'b0;
    repeat (3) step();
    held = count;
    check(held == 14, "R8 count after disable", held, 14);
    seen = 1'b0;
    repeat (20) begin
      step();
      if (pe) seen = 1'b1;
    end
    check(count == held, "R8 count holds", count, held);
    check(!seen, "R8 no events while off", seen, 0);
    en = 1'b1;
    repeat (3) step();
    check(count == 20, "R8 re-enable reloads", count, 20);
  endtask

  task automatic t_zero();
    bit seen;
    stop();
    sel = 2'd0; rel = 8'd0;
    step();
    en = 1'b1;
    seen = 1'b0;
    repeat (60) begin
      step();
      if (pe) seen = 1'b1;
    end
    check(count == 0, "R7 count stays zero", count, 0);
    check(!seen, "R7 no events", seen, 0);
  endtask

  initial begin
    t_reset();
    t_sync_latency();
    run_case(0, 3);
    run_case(0, 1);
    run_case(1, 2);
    run_case(1, 5);
    run_case(2, 3);
    run_case(2, 1);
    run_case(3, 2);
    run_case(3, 1);
    t_reload_change();
    t_disable();
    t_zero();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule